// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks, so a producer and a consumer can move 36-bit words at the same time. Pointers cross between the two domains as Gray code through a chain of synchronizer flops. Full and half-full are worked out on the write side, and empty on the read side. Two threshold flags, almost-empty and almost-full, warn before the hard limits are reached. Their offsets start from one of eight presets and can later be rewritten either bit by bit or as whole words taken from the data bus.

Two timing styles are available on the read port, and the choice is made while master reset is held. In standard timing, a word is fetched only when a read is requested, and the two status outputs mean "empty" and "full". In fall-through timing, the oldest word appears on the output without any request, and the same two outputs mean "data ready" and "space available". The threshold flags can be taken either straight from the pointer comparison or from a register one cycle later. That choice is also made at master reset.

Master reset returns everything to its defaults. Partial reset only empties the buffer. A rewind request sends the read side back to storage location zero, so that data written since reset can be read again.

Top module: `dcf_fifo`

## Requirements
- R1: While master reset is held, the mode inputs are captured. After it is released, with no data stored, standard timing shows rd_flag=1 (empty) and wr_flag=0 (not full), and fall-through timing shows rd_flag=0 (not ready) and wr_flag=1 (space). In both cases half_full=0, almost_empty=1 and almost_full=0.
- R2: In standard timing, words leave in the order they were written. A read is accepted at a rclk edge when ren=1 and the FIFO is not empty, and dout shows the word after that edge.
- R3: The FIFO holds 2**ADDR_W words (16 by default). Once it holds that many, standard-timing wr_flag is 1, and further writes are dropped without changing the stored data.
- R4: A read request while the FIFO is empty (standard timing) leaves dout and the read pointer unchanged, and later data is still returned correctly.
- R5: half_full is 1 exactly when the stored count is greater than half the depth.
- R6: At master reset, the preset index {cfg_load, preset_sel[1:0]} (values 0 to 7) selects the offset 2**(index+3)-1 for both threshold flags, capped at depth-1. almost_empty is 1 when the count is at or below its offset, and almost_full is 1 when the free space is at or below its offset.
- R7: Each wclk edge with ser_en=1 (and no parallel load) shifts ser_in into a 2*ADDR_W-bit offset chain. After 2*ADDR_W shifts, the bits sent first form the almost-empty offset, least significant bit first, followed by the almost-full offset, least significant bit first.
- R8: A wclk edge with cfg_load=1 and wen=1 stores din[ADDR_W-1:0] as an offset and writes no data. Such loads alternate between the almost-empty offset (the first load after master reset) and the almost-full offset.
- R9: Partial reset empties the FIFO but keeps the offsets and the timing modes captured at the last master reset.
- R10: In fall-through timing, the oldest word appears on dout with rd_flag=1 without any read request. Each read with rd_flag=1 moves to the next word. A read of the last word drops rd_flag to 0.
- R11: A one-cycle rewind pulse sets the read pointer back to location zero. In standard timing, the next read returns the first word written since reset. In fall-through timing, dout shows that word with rd_flag=1 right after the rewind edge.
- R12: With flag_direct=1 captured at master reset, almost_empty and almost_full change in the same cycle as the pointer movement that causes the change. With flag_direct=0, they change one cycle of their own clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, synchronous in both domains, held for at least 4 cycles of each clock |
| prst | input | 1 | Partial reset, active high, same holding rule |
| fall_through | input | 1 | Read timing captured at master reset: 1 selects fall-through, 0 selects standard |
| flag_direct | input | 1 | Threshold-flag timing captured at master reset: 1 selects direct, 0 selects registered |
| preset_sel | input | 2 | Low two bits of the preset offset index, sampled at master reset |
| cfg_load | input | 1 | High bit of the preset index during master reset; afterwards, selects parallel offset loading |
| wen | input | 1 | Write request |
| din | input | DATA_W | Write data, and offset value during a parallel load |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset data bit |
| ren | input | 1 | Read request |
| rewind | input | 1 | Retransmit request (read clock domain) |
| dout | output | DATA_W | Read data register |
| rd_flag | output | 1 | Empty (standard) or data ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or space available (fall-through) |
| half_full | output | 1 | More than half the depth is stored |
| almost_empty | output | 1 | Stored count is at or below the almost-empty offset |
| almost_full | output | 1 | Free space is at or below the almost-full offset |

## Verification
The hardest case to reach is the one-cycle difference between direct and registered threshold flags. This difference shows only in the half read-clock cycle right after the read that takes the count below the almost-empty offset. The bench fills the FIFO to exactly one word above the offset and lets the synchronizers settle. It then issues a single read and samples at the next falling edge, once in each flag mode. A second hard case is rewind in fall-through mode after the output has already drained. To reach it, the bench reads past the last word before pulsing rewind.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   // Threshold preset: 2**(idx+3)-1, limited to depth-1.
   function automatic int preset_offset(input int idx, input int depth);
      int v;
      v = (1 << (idx + 3)) - 1;
      if (v > depth - 1) v = depth - 1;
      return v;
   endfunction

   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dcf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ofs.sv
module dcf_ofs #(
   parameter int OW    = 4,
   parameter int DEPTH = 16
) (
   input  logic          wclk,
   input  logic          mrst,
   input  logic          cfg_load,
   input  logic [1:0]    preset_sel,
   input  logic          wen,
   input  logic [OW-1:0] pdata,
   input  logic          ser_en,
   input  logic          ser_in,
   output logic [OW-1:0] ae_ofs,
   output logic [OW-1:0] af_ofs
);
   import dcf_pkg::*;

   localparam int CW = 2 * OW;

   logic [CW-1:0] chain;
   logic          to_af;
   logic [2:0]    idx;
   logic [OW-1:0] preset_val;

   assign idx        = {cfg_load, preset_sel};
   assign preset_val = OW'(preset_offset(int'(idx), DEPTH));

   always_ff @(posedge wclk) begin
      if (mrst) begin
         chain <= {preset_val, preset_val};
         to_af <= 1'b0;
      end else if (cfg_load && wen) begin
         if (to_af) chain[CW-1:OW] <= pdata;
         else       chain[OW-1:0]  <= pdata;
         to_af <= ~to_af;
      end else if (ser_en) begin
         chain <= {ser_in, chain[CW-1:1]};
      end
   end

   assign ae_ofs = chain[OW-1:0];
   assign af_ofs = chain[CW-1:OW];

   // Offsets change only through master reset or a load; partial reset never touches them.
   assert_ofs_hold_R9: assert property (@(posedge wclk) disable iff (mrst)
      (!(cfg_load && wen) && !ser_en) |=> $stable(chain));
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
   parameter int AW     = 4,
   parameter int STAGES = 2
) (
   input  logic          wclk,
   input  logic          mrst,
   input  logic          prst,
   input  logic          fall_through,
   input  logic          flag_direct,
   input  logic          wen,
   input  logic          cfg_load,
   input  logic [AW:0]   rgray,
   input  logic [AW-1:0] af_ofs,
   output logic          mem_we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic          wr_flag,
   output logic          half_full,
   output logic          almost_full
);
   import dcf_pkg::*;

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] wbin, wbin_nxt, rsync, rbin, wcount, free;
   logic          full, fwft_q, direct_q, paf_c, paf_q;

   dcf_sync #(.W(PW), .STAGES(STAGES)) u_rsync (.clk(wclk), .d(rgray), .q(rsync));

   assign rbin   = PW'(gray_to_bin(32'(rsync)));
   assign wcount = wbin - rbin;
   assign free   = PW'(DEPTH) - wcount;
   assign full   = (wcount == PW'(DEPTH));
   assign mem_we = wen && !cfg_load && !full && !mrst && !prst;
   assign waddr  = wbin[AW-1:0];
   assign wbin_nxt = mem_we ? wbin + 1'b1 : wbin;
   assign paf_c  = (free <= {1'b0, af_ofs});

   always_ff @(posedge wclk) begin
      if (mrst) begin
         fwft_q   <= fall_through;
         direct_q <= flag_direct;
      end
      if (mrst || prst) begin
         wbin  <= '0;
         wgray <= '0;
         paf_q <= 1'b0;
      end else begin
         wbin  <= wbin_nxt;
         wgray <= wbin_nxt ^ (wbin_nxt >> 1);
         paf_q <= paf_c;
      end
   end

   assign wr_flag     = fwft_q ? !full : full;
   assign half_full   = (wcount > PW'(DEPTH / 2));
   assign almost_full = direct_q ? paf_c : paf_q;

   assert_full_blocks_R3: assert property (@(posedge wclk) disable iff (mrst || prst)
      (full && wen && !cfg_load) |=> $stable(wbin));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
   parameter int AW     = 4,
   parameter int DW     = 36,
   parameter int STAGES = 2
) (
   input  logic          rclk,
   input  logic          mrst,
   input  logic          prst,
   input  logic          fall_through,
   input  logic          flag_direct,
   input  logic          ren,
   input  logic          rewind,
   input  logic [AW:0]   wgray,
   input  logic [AW-1:0] ae_ofs,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dout,
   output logic          rd_flag,
   output logic          almost_empty
);
   import dcf_pkg::*;

   localparam int PW = AW + 1;

   logic [PW-1:0] rbin, rbin_nxt, wsync, wbin_s, rcount;
   logic          empty, load, fwft_q, direct_q, or_q, pae_c, pae_q, have_any;

   dcf_sync #(.W(PW), .STAGES(STAGES)) u_wsync (.clk(rclk), .d(wgray), .q(wsync));

   assign wbin_s   = PW'(gray_to_bin(32'(wsync)));
   assign rcount   = wbin_s - rbin;
   assign empty    = (rcount == '0);
   assign have_any = (wbin_s != '0);
   assign load     = fwft_q ? ((!or_q || ren) && !empty) : (ren && !empty);
   assign raddr    = rewind ? '0 : rbin[AW-1:0];
   assign pae_c    = (rcount <= {1'b0, ae_ofs});

   always_comb begin
      rbin_nxt = rbin;
      if (rewind) rbin_nxt = (fwft_q && have_any) ? PW'(1) : '0;
      else if (load) rbin_nxt = rbin + 1'b1;
   end

   always_ff @(posedge rclk) begin
      if (mrst) begin
         fwft_q   <= fall_through;
         direct_q <= flag_direct;
      end
      if (mrst || prst) begin
         rbin  <= '0;
         rgray <= '0;
         dout  <= '0;
         or_q  <= 1'b0;
         pae_q <= 1'b1;
      end else begin
         rbin  <= rbin_nxt;
         rgray <= rbin_nxt ^ (rbin_nxt >> 1);
         pae_q <= pae_c;
         if (rewind) begin
            if (fwft_q && have_any) begin
               dout <= rdata;
               or_q <= 1'b1;
            end
         end else if (load) begin
            dout <= rdata;
            or_q <= 1'b1;
         end else if (fwft_q && ren) begin
            or_q <= 1'b0;
         end
      end
   end

   assign rd_flag      = fwft_q ? or_q : empty;
   assign almost_empty = direct_q ? pae_c : pae_q;

   assert_std_advance_R2: assert property (@(posedge rclk) disable iff (mrst || prst)
      (!fwft_q && ren && !empty && !rewind) |=> (rbin == $past(rbin) + 1'b1));
   assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (mrst || prst)
      (!fwft_q && ren && empty && !rewind) |=> ($stable(rbin) && $stable(dout)));
   assert_fwft_hold_R10: assert property (@(posedge rclk) disable iff (mrst || prst)
      (fwft_q && or_q && !ren && !rewind) |=> ($stable(dout) && or_q));
   assert_rewind_std_R11: assert property (@(posedge rclk) disable iff (mrst || prst)
      (rewind && !fwft_q) |=> (rbin == '0));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
   parameter int DATA_W      = 36,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              fall_through,
   input  logic              flag_direct,
   input  logic [1:0]        preset_sel,
   input  logic              cfg_load,
   input  logic              wen,
   input  logic [DATA_W-1:0] din,
   input  logic              ser_en,
   input  logic              ser_in,
   input  logic              ren,
   input  logic              rewind,
   output logic [DATA_W-1:0] dout,
   output logic              rd_flag,
   output logic              wr_flag,
   output logic              half_full,
   output logic              almost_empty,
   output logic              almost_full
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_depth
         $error("dcf_fifo: ADDR_W must lie in 2..12");
      end
      if (DATA_W < ADDR_W) begin : g_bad_width
         $error("dcf_fifo: DATA_W must cover an offset value");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
   logic [ADDR_W:0]   wgray, rgray;
   logic              mem_we;

   always_ff @(posedge wclk) begin
      if (mem_we) mem[waddr] <= din;
   end

   dcf_ofs #(.OW(ADDR_W), .DEPTH(DEPTH)) u_ofs (
      .wclk(wclk), .mrst(mrst), .cfg_load(cfg_load), .preset_sel(preset_sel),
      .wen(wen), .pdata(din[ADDR_W-1:0]), .ser_en(ser_en), .ser_in(ser_in),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs));

   dcf_wr_ctl #(.AW(ADDR_W), .STAGES(SYNC_STAGES)) u_wr (
      .wclk(wclk), .mrst(mrst), .prst(prst), .fall_through(fall_through),
      .flag_direct(flag_direct), .wen(wen), .cfg_load(cfg_load), .rgray(rgray),
      .af_ofs(af_ofs), .mem_we(mem_we), .waddr(waddr), .wgray(wgray),
      .wr_flag(wr_flag), .half_full(half_full), .almost_full(almost_full));

   dcf_rd_ctl #(.AW(ADDR_W), .DW(DATA_W), .STAGES(SYNC_STAGES)) u_rd (
      .rclk(rclk), .mrst(mrst), .prst(prst), .fall_through(fall_through),
      .flag_direct(flag_direct), .ren(ren), .rewind(rewind), .wgray(wgray),
      .ae_ofs(ae_ofs), .rdata(mem[raddr]), .raddr(raddr), .rgray(rgray),
      .dout(dout), .rd_flag(rd_flag), .almost_empty(almost_empty));
endmodule

// File: tb/dcf_fifo_bench.sv
`timescale 1ns/1ps
module dcf_fifo_bench;
   localparam int DW = 36;

   logic wclk = 1'b0, rclk = 1'b0;
   logic mrst = 1'b1, prst = 1'b0, fall_through = 1'b0, flag_direct = 1'b0;
   logic [1:0] preset_sel = 2'd0;
   logic cfg_load = 1'b0, wen = 1'b0, ser_en = 1'b0, ser_in = 1'b0, ren = 1'b0, rewind = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic rd_flag, wr_flag, half_full, almost_empty, almost_full;

   int checks = 0, errors = 0;
   logic [DW-1:0] rv;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   dcf_fifo u_dcf_fifo (
      .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fall_through(fall_through),
      .flag_direct(flag_direct), .preset_sel(preset_sel), .cfg_load(cfg_load), .wen(wen),
      .din(din), .ser_en(ser_en), .ser_in(ser_in), .ren(ren), .rewind(rewind),
      .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
      .almost_empty(almost_empty), .almost_full(almost_full));

   // {preset index, words written, almost_empty, almost_full, half_full}
   localparam logic [10:0] VEC [0:8] = '{
      {3'd0, 5'd0,  3'b100}, {3'd0, 5'd7,  3'b100}, {3'd0, 5'd8,  3'b000},
      {3'd0, 5'd9,  3'b011}, {3'd0, 5'd16, 3'b011}, {3'd1, 5'd0,  3'b100},
      {3'd1, 5'd1,  3'b110}, {3'd1, 5'd16, 3'b011}, {3'd5, 5'd9,  3'b111}};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge rclk);
   endtask

   task automatic do_mrst(input logic [2:0] idx, input logic ft, input logic dir);
      @(negedge wclk);
      mrst = 1'b1; cfg_load = idx[2]; preset_sel = idx[1:0];
      fall_through = ft; flag_direct = dir;
      repeat (6) @(negedge rclk);
      @(negedge wclk);
      mrst = 1'b0; cfg_load = 1'b0;
      settle();
   endtask

   task automatic do_prst();
      @(negedge wclk);
      prst = 1'b1;
      repeat (6) @(negedge rclk);
      @(negedge wclk);
      prst = 1'b0;
      settle();
   endtask

   task automatic wr(input logic [DW-1:0] v);
      @(negedge wclk); wen = 1'b1; din = v;
      @(negedge wclk); wen = 1'b0;
   endtask

   task automatic rd(output logic [DW-1:0] v);
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
      v = dout;
   endtask

   task automatic shift_bit(input logic b);
      @(negedge wclk); ser_en = 1'b1; ser_in = b;
      @(negedge wclk); ser_en = 1'b0;
   endtask

   task automatic pulse_rewind();
      @(negedge rclk); rewind = 1'b1;
      @(negedge rclk); rewind = 1'b0;
   endtask

   initial begin
      #1000000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // Table walk: presets, threshold flags, half-full (R1, R3, R5, R6)
      for (int e = 0; e < 9; e++) begin
         do_mrst(VEC[e][10:8], 1'b0, 1'b0);
         for (int i = 0; i < int'(VEC[e][7:3]); i++) wr(DW'(i));
         settle();
         chk($sformatf("R6 almost_empty vec%0d", e), 64'(almost_empty), 64'(VEC[e][2]));
         chk($sformatf("R6 almost_full vec%0d", e),  64'(almost_full),  64'(VEC[e][1]));
         chk($sformatf("R5 half_full vec%0d", e),    64'(half_full),    64'(VEC[e][0]));
         if (VEC[e][7:3] == 5'd0) begin
            chk("R1 std empty after reset", 64'(rd_flag), 64'd1);
            chk("R1 std not full after reset", 64'(wr_flag), 64'd0);
         end
         if (VEC[e][7:3] == 5'd16) chk("R3 full after depth writes", 64'(wr_flag), 64'd1);
      end

      // R1 fall-through reset state
      do_mrst(3'd0, 1'b1, 1'b0);
      chk("R1 fwft not ready", 64'(rd_flag), 64'd0);
      chk("R1 fwft space", 64'(wr_flag), 64'd1);
      chk("R1 fwft almost_empty", 64'(almost_empty), 64'd1);

      // R2 / R3 / R4: overfill, drain in order, read on empty
      do_mrst(3'd0, 1'b0, 1'b0);
      for (int i = 0; i < 17; i++) wr(DW'(36'h100 + i));
      settle();
      chk("R3 full flag", 64'(wr_flag), 64'd1);
      for (int i = 0; i < 16; i++) begin
         rd(rv);
         chk("R2 order", 64'(rv), 64'(36'h100 + i));
      end
      settle();
      chk("R3 extra word dropped, empty", 64'(rd_flag), 64'd1);
      rd(rv);
      chk("R4 dout unchanged on empty read", 64'(rv), 64'h10F);
      chk("R4 still empty", 64'(rd_flag), 64'd1);
      wr(36'hABC);
      settle();
      rd(rv);
      chk("R4 pointer intact", 64'(rv), 64'hABC);

      // R7 serial load: almost-empty offset 3, almost-full offset 2
      do_mrst(3'd0, 1'b0, 1'b0);
      shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b0);
      shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b0);
      for (int i = 0; i < 3; i++) wr(DW'(i));
      settle();
      chk("R7 almost_empty at 3", 64'(almost_empty), 64'd1);
      wr(36'd3);
      settle();
      chk("R7 almost_empty at 4", 64'(almost_empty), 64'd0);
      for (int i = 0; i < 9; i++) wr(DW'(i));
      settle();
      chk("R7 almost_full at 13", 64'(almost_full), 64'd0);
      wr(36'd9);
      settle();
      chk("R7 almost_full at 14", 64'(almost_full), 64'd1);

      // R9 partial reset keeps offsets and standard timing
      fall_through = 1'b1;
      do_prst();
      chk("R9 empty after partial reset", 64'(rd_flag), 64'd1);
      chk("R9 almost_full cleared", 64'(almost_full), 64'd0);
      for (int i = 0; i < 3; i++) wr(DW'(i));
      settle();
      chk("R9 offset kept, count 3", 64'(almost_empty), 64'd1);
      wr(36'd3);
      settle();
      chk("R9 offset kept, count 4", 64'(almost_empty), 64'd0);
      fall_through = 1'b0;

      // R8 parallel load: almost-empty 5, almost-full 10
      do_mrst(3'd0, 1'b0, 1'b0);
      @(negedge wclk); cfg_load = 1'b1;
      wr(36'd5); wr(36'd10);
      @(negedge wclk); cfg_load = 1'b0;
      settle();
      chk("R8 load writes no data", 64'(rd_flag), 64'd1);
      for (int i = 0; i < 5; i++) wr(DW'(i));
      settle();
      chk("R8 almost_empty at 5", 64'(almost_empty), 64'd1);
      chk("R8 almost_full at 5", 64'(almost_full), 64'd0);
      wr(36'd5);
      settle();
      chk("R8 almost_empty at 6", 64'(almost_empty), 64'd0);
      chk("R8 almost_full at 6", 64'(almost_full), 64'd1);

      // R10 / R11 fall-through and rewind
      do_mrst(3'd0, 1'b1, 1'b0);
      wr(36'hA0); wr(36'hA1); wr(36'hA2);
      settle();
      chk("R10 ready without read", 64'(rd_flag), 64'd1);
      chk("R10 first word shown", 64'(dout), 64'hA0);
      rd(rv);
      chk("R10 second word", 64'(rv), 64'hA1);
      rd(rv);
      chk("R10 third word", 64'(rv), 64'hA2);
      chk("R10 ready on last word", 64'(rd_flag), 64'd1);
      rd(rv);
      chk("R10 not ready after last read", 64'(rd_flag), 64'd0);
      chk("R10 space flag", 64'(wr_flag), 64'd1);
      pulse_rewind();
      chk("R11 fwft rewind data", 64'(dout), 64'hA0);
      chk("R11 fwft rewind ready", 64'(rd_flag), 64'd1);
      rd(rv);
      chk("R11 fwft after rewind", 64'(rv), 64'hA1);

      // R11 standard rewind
      do_mrst(3'd0, 1'b0, 1'b0);
      wr(36'hB0); wr(36'hB1); wr(36'hB2); wr(36'hB3);
      settle();
      rd(rv); rd(rv);
      chk("R11 std before rewind", 64'(rv), 64'hB1);
      pulse_rewind();
      rd(rv);
      chk("R11 std rewind first word", 64'(rv), 64'hB0);

      // R12 direct vs registered threshold timing (offset 7)
      do_mrst(3'd0, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) wr(DW'(i));
      settle();
      chk("R12 direct before read", 64'(almost_empty), 64'd0);
      rd(rv);
      chk("R12 direct same cycle", 64'(almost_empty), 64'd1);
      do_mrst(3'd0, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) wr(DW'(i));
      settle();
      rd(rv);
      chk("R12 registered lags", 64'(almost_empty), 64'd0);
      @(negedge rclk);
      chk("R12 registered one cycle later", 64'(almost_empty), 64'd1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule